// File: doc/BRIEF.md
# Clock Frequency Meter

The block measures how fast one of several monitored clocks runs compared with the reference clock that times the block itself. Software writes a window length and a channel number into the control register, turns on the free-run enable in the monitor/status register, and then sets the meter enable bit. The block waits for the first rising edge of the chosen monitored clock. From that edge it counts reference cycles until the monitored clock has completed the programmed number of cycles. The count is then copied into the value register and the valid flag is raised, so software can poll for it.

Each monitored clock is brought into the reference domain through a two-stage synchronizer, and its rising edges are detected there. For this to work, the reference clock must run at least twice as fast as any monitored clock. A running measurement does not advance while the free-run enable is clear. The stored result saturates instead of wrapping. A monitored clock that never toggles never produces a result.

Top module: `freq_meter`

## Requirements
- R1: After reset, the control register (offset 0x00), the value register (offset 0x0C) and the monitor/status register (offset 0x10) all read 0.
- R2: The control register reads back the window in bits [23:0], the meter enable in bit 24 and the channel select in bits [27:26]. Bit 8 of the monitor/status register (free-run enable) reads back as written.
- R3: With the free-run enable set, a measurement sets status bit 0 (valid) and latches into the value register the number of reference cycles taken by `window` monitored-clock periods. For a monitored period of P reference cycles, this is exactly window×P.
- R4: The channel select picks which of the four monitored clocks is measured, so different channels give results that follow their own periods.
- R5: While the free-run enable is 0, an armed measurement makes no progress: valid stays 0 and the value stays 0. Setting the enable later lets it finish with the normal result.
- R6: If the selected monitored clock is stopped, valid never rises and the value register reads 0.
- R7: The value register saturates at 2^VAL_W−1 instead of wrapping.
- R8: Writing 0 to the meter enable clears valid. The last result stays readable in the value register.
- R9: A 0-to-1 change of the meter enable starts a new measurement, and that start clears both valid and the value register to 0.
- R10: A window field of 0 is handled as a window of 1.
- R11: Writes to the value register and to the valid bit have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; also times the register interface |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on the next cycle |
| reg_addr | input | 8 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| mon_clk | input | NCH (4) | Monitored clocks, one per channel |

## Verification
The monitored clocks are made by the bench as exact divisions of the reference, with periods of 4, 6 and 10 reference cycles plus one stopped channel. Because the periods are exact, each result must equal window×period exactly. Measuring the same window on different channels shows that the select works. Changing the window on one channel separates the window term from the period term. A window of 0 shows the minimum-window rule. A stopped channel, a cleared free-run enable, and a very slow clock that overflows a narrowed value register each test a corner that normal measurements never reach. Restarting from a held result shows that a new start clears the value, and clearing the enable shows that the result is kept.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int BUS_W     = 32;
  localparam int ADDR_W    = 8;
  localparam int WIN_W     = 24;
  localparam int SEL_W     = 2;
  localparam int EN_BIT    = 24;
  localparam int SEL_LSB   = 26;
  localparam int FRCK_BIT  = 8;
  localparam int VALID_BIT = 0;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] ADDR_VALUE = 8'h0C;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 8'h10;

  typedef enum logic [1:0] {ST_IDLE, ST_ALIGN, ST_RUN, ST_DONE} meas_st_t;
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
  parameter int NCH    = 4,
  parameter int STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] mon_i,
  output logic [NCH-1:0] rise_o
);
  localparam int SH_W = STAGES + 1;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [SH_W-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[SH_W-2:0], mon_i[g]};
    end
    // rising edge seen after the synchronizer stages
    assign rise_o[g] = sh[SH_W-2] & ~sh[SH_W-1];
  end
endmodule

// File: rtl/fm_core.sv
module fm_core
  import fm_pkg::*;
#(
  parameter int VAL_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             frck_i,
  input  logic [WIN_W-1:0] win_i,
  input  logic             rise_i,
  output logic [VAL_W-1:0] result_o,
  output logic             valid_o
);
  meas_st_t         st;
  logic             en_q;
  logic             start;
  logic [VAL_W-1:0] cnt, cnt_nxt;
  logic [WIN_W-1:0] seen, seen_nxt, tgt;

  assign start    = en_i & ~en_q;
  assign tgt      = (win_i == '0) ? WIN_W'(1) : win_i;
  assign cnt_nxt  = (&cnt) ? cnt : cnt + VAL_W'(1);
  assign seen_nxt = seen + WIN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      en_q     <= 1'b0;
      cnt      <= '0;
      seen     <= '0;
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      en_q <= en_i;
      if (!en_i) begin
        st      <= ST_IDLE;
        valid_o <= 1'b0;
      end else if (start) begin
        st       <= ST_ALIGN;
        valid_o  <= 1'b0;
        result_o <= '0;
        cnt      <= '0;
        seen     <= '0;
      end else if (frck_i) begin
        unique case (st)
          ST_ALIGN: begin
            if (rise_i) begin
              st   <= ST_RUN;
              cnt  <= '0;
              seen <= '0;
            end
          end
          ST_RUN: begin
            cnt <= cnt_nxt;
            if (rise_i) begin
              seen <= seen_nxt;
              if (seen_nxt == tgt) begin
                result_o <= cnt_nxt;
                valid_o  <= 1'b1;
                st       <= ST_DONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_VALID_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !valid_o); // R8
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> (!valid_o && result_o == '0)); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && (&cnt) && en_i && en_q && frck_i) |=> (&cnt)); // R7
  AST_FRCK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en_i && !start && !frck_i) |=> ($stable(result_o) && $stable(valid_o))); // R5
endmodule

// File: rtl/fm_regs.sv
module fm_regs
  import fm_pkg::*;
#(
  parameter int VAL_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [VAL_W-1:0]  result_i,
  input  logic              valid_i,
  output logic              en_o,
  output logic              frck_o,
  output logic [WIN_W-1:0]  win_o,
  output logic [SEL_W-1:0]  sel_o
);
  logic [BUS_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o   <= 1'b0;
      frck_o <= 1'b0;
      win_o  <= '0;
      sel_o  <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_CTRL) begin
        win_o <= wdata_i[WIN_W-1:0];
        en_o  <= wdata_i[EN_BIT];
        sel_o <= wdata_i[SEL_LSB +: SEL_W];
      end
      if (addr_i == ADDR_STAT) frck_o <= wdata_i[FRCK_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rd_mux[WIN_W-1:0]           = win_o;
        rd_mux[EN_BIT]              = en_o;
        rd_mux[SEL_LSB +: SEL_W]    = sel_o;
      end
      ADDR_VALUE: rd_mux[VAL_W-1:0] = result_i;
      ADDR_STAT: begin
        rd_mux[VALID_BIT] = valid_i;
        rd_mux[FRCK_BIT]  = frck_o;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_i && addr_i == ADDR_CTRL) |=> (en_o == $past(wdata_i[EN_BIT]))); // R2
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import fm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int VAL_W  = 32,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic [NCH-1:0]    mon_clk
);
  localparam int NSEL = 1 << SEL_W;

  logic [NCH-1:0]   rise_vec;
  logic [NSEL-1:0]  rise_pad;
  logic             rise_sel;
  logic             en, frck, valid;
  logic [WIN_W-1:0] win;
  logic [SEL_W-1:0] sel;
  logic [VAL_W-1:0] result;

  fm_sync #(.NCH(NCH), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst(rst), .mon_i(mon_clk), .rise_o(rise_vec)
  );

  always_comb begin
    rise_pad = '0;
    rise_pad[NCH-1:0] = rise_vec;
  end
  assign rise_sel = rise_pad[sel];

  fm_core #(.VAL_W(VAL_W)) u_core (
    .clk(clk), .rst(rst), .en_i(en), .frck_i(frck), .win_i(win),
    .rise_i(rise_sel), .result_o(result), .valid_o(valid)
  );

  fm_regs #(.VAL_W(VAL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_i(reg_wr), .rd_i(reg_rd), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .result_i(result),
    .valid_i(valid), .en_o(en), .frck_o(frck), .win_o(win), .sel_o(sel)
  );
endmodule

// File: tb/sim_freq_meter.sv
module sim_freq_meter;
  localparam int VW   = 12;
  localparam int SATV = (1 << VW) - 1;
  localparam int WDOG = 190000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  mon = '0;
  int          hp [4];
  int          ctr [4] = '{default: 0};
  int          checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  freq_meter #(.NCH(4), .VAL_W(VW)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_clk(mon)
  );

  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      if (hp[i] == 0) begin
        mon[i] <= 1'b0;
        ctr[i] <= 0;
      end else if (ctr[i] >= hp[i] - 1) begin
        ctr[i] <= 0;
        mon[i] <= ~mon[i];
      end else ctr[i] <= ctr[i] + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: act=%0d exp<%0d cycles", cyc, WDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  function automatic logic [31:0] ctl(input int sel, input int win, input bit en);
    return (32'(sel) << 26) | (32'(en) << 24) | (32'(win) & 32'hFF_FFFF);
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poll(input string req, input int limit);
    logic [31:0] s;
    int k = 0;
    do begin rd(8'h10, s); k++; end while (!s[0] && k < limit);
    chk(req, {31'b0, s[0]}, 32'd1);
  endtask

  task automatic measure(input string req, input int sel, input int win, input int exp, input int limit);
    logic [31:0] v;
    wr(8'h00, ctl(sel, win, 1'b0));
    wr(8'h00, ctl(sel, win, 1'b1));
    poll(req, limit);
    rd(8'h0C, v);
    chk(req, v, 32'(exp));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v); chk("R1 ctrl", v, 0);
    rd(8'h0C, v); chk("R1 value", v, 0);
    rd(8'h10, v); chk("R1 status", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(8'h00, ctl(2, 24'h123456, 1'b0));
    rd(8'h00, v); chk("R2 ctrl readback", v, 32'h0812_3456);
    wr(8'h10, 32'h101);
    rd(8'h10, v); chk("R11 valid bit not writable, R2 free-run bit", v, 32'h100);
  endtask

  task automatic t_measure();
    measure("R3 ch0 win50", 0, 50, 200, 2000);
    measure("R4 ch1 win50", 1, 50, 300, 2000);
    measure("R4 ch2 win20", 2, 20, 200, 2000);
    measure("R3 ch0 win100", 0, 100, 400, 2000);
  endtask

  task automatic t_win0();
    measure("R10 window 0", 1, 0, 6, 500);
  endtask

  task automatic t_ro_value();
    logic [31:0] v;
    wr(8'h0C, 32'hFFF);
    rd(8'h0C, v); chk("R11 value write ignored", v, 6);
  endtask

  task automatic t_disable();
    logic [31:0] v;
    wr(8'h00, ctl(1, 0, 1'b0));
    idle(2);
    rd(8'h10, v); chk("R8 valid cleared", {31'b0, v[0]}, 0);
    rd(8'h0C, v); chk("R8 value held", v, 6);
  endtask

  task automatic t_restart();
    logic [31:0] v;
    wr(8'h00, ctl(2, 200, 1'b1));
    idle(2);
    rd(8'h10, v); chk("R9 valid cleared at start", {31'b0, v[0]}, 0);
    rd(8'h0C, v); chk("R9 value cleared at start", v, 0);
    poll("R9 restart completes", 5000);
    rd(8'h0C, v); chk("R9 new result", v, 2000);
  endtask

  task automatic t_frck();
    logic [31:0] v;
    wr(8'h10, 32'h0);
    wr(8'h00, ctl(0, 10, 1'b0));
    wr(8'h00, ctl(0, 10, 1'b1));
    idle(500);
    rd(8'h10, v); chk("R5 no valid without free-run", {31'b0, v[0]}, 0);
    rd(8'h0C, v); chk("R5 value 0 without free-run", v, 0);
    wr(8'h10, 32'h100);
    poll("R5 completes after free-run set", 500);
    rd(8'h0C, v); chk("R5 result", v, 40);
  endtask

  task automatic t_stopped();
    logic [31:0] v;
    wr(8'h00, ctl(3, 5, 1'b0));
    wr(8'h00, ctl(3, 5, 1'b1));
    idle(1000);
    rd(8'h10, v); chk("R6 stopped clock no valid", {31'b0, v[0]}, 0);
    rd(8'h0C, v); chk("R6 stopped clock value 0", v, 0);
  endtask

  task automatic t_sat();
    hp[2] = 1000;
    idle(4);
    measure("R7 saturation", 2, 4, SATV, 20000);
  endtask

  initial begin
    hp[0] = 2; hp[1] = 3; hp[2] = 5; hp[3] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_measure();
    t_win0();
    t_ro_value();
    t_disable();
    t_restart();
    t_frck();
    t_stopped();
    t_sat();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule